// File: doc/BRIEF.md
# Transactional Line Cache

A small fully associative cache of single-word lines that sits next to a processor and lets it run lock-free transactions. The processor issues transactional loads (plain or with intent to write), transactional stores, and the three control operations validate, commit and abort. Every entry carries a transactional tag: empty, normal, commit-copy or abort-copy. When a transaction first touches a line, the cache keeps two copies. The commit-copy holds the value from before the transaction. The abort-copy takes all transactional updates. Commit and abort then only retag entries inside the cache and use no bus cycles.

Toward memory, the block masters a simple request/acknowledge bus. It uses that bus for transactional reads, exclusive transactional reads and write-backs. It also watches snooped cycles from other agents, and it answers them with data or with a busy refusal that makes the requester's transaction fail. Two flags are visible at the ports: one shows that a transaction is in progress, and the other shows that the transaction is still healthy rather than aborted.

The processor presents one operation while `op_ready` is high. It then waits for the one-cycle `resp_valid` pulse, which carries the result.

Top module: `tcache`

## Requirements
- R1: After reset all entries are empty, `tactive` is 0, `tstatus` is 1, `bm_req` is 0, `op_ready` is 1, and no snoop hits.
- R2: A transactional load (op_code 0) that misses puts a read on the bus with bm_cmd 0 at its address. An exclusive load (1) or a store (2) that misses uses bm_cmd 1. The fetched word (or the stored word, for a store) is returned with resp_ok 1, and `tactive` rises. The request and its address stay steady until `bm_ack`.
- R3: A load, exclusive load or store that hits the abort-copy of a line reads or writes it in place with no bus cycle, so a later load returns the stored word.
- R4: A transactional access that hits a normal line makes a second copy of that line with no bus cycle. The old value stays visible to snooped transactional reads.
- R5: COMMIT (op_code 4) with `tstatus` 1 returns resp_ok 1 and clears `tactive`. Updated words become normal lines, and the commit-copies are freed.
- R6: ABORT (op_code 5) returns resp_ok 1, clears `tactive`, discards the updates and turns the commit-copies back into normal lines that hold the old value.
- R7: A bus read answered with `bm_busy` aborts the transaction: resp_ok is 0, `tstatus` becomes 0 and `tactive` stays 1. Further loads and stores then answer resp_ok 0 with no bus cycle and no change to the cache.
- R8: VALIDATE (op_code 3) and COMMIT return `tstatus` in resp_ok. When it is 0, `tstatus` returns to 1 and `tactive` to 0. When it is 1, VALIDATE leaves both flags alone.
- R9: Room for a new entry is taken from empty entries first, then from normal lines (lowest index first), then from commit-copies. A clean normal line is dropped silently. A dirty normal line or a commit-copy is first written back with bm_cmd 2, carrying its address and word.
- R10: If a transactional access cannot find the entries it needs, and only abort-copies remain, it answers resp_ok 0 with resp_ovf 1 and aborts the transaction exactly as in R7.
- R11: A snooped READ (sn_cmd 0) or T_READ (1) that hits a normal line gets `sn_hit` with that line's word. A snooped RFO (2) or T_RFO (3) also gets the word, and it frees the line.
- R12: While `tstatus` is 1, a snooped T_READ that hits a commit-copy gets `sn_hit` with the pre-transaction word. Any other snooped cycle that hits a transactional entry gets `sn_busy` and no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Processor operation present |
| op_ready | output | 1 | Block can take an operation |
| op_code | input | 3 | 0 load, 1 exclusive load, 2 store, 3 validate, 4 commit, 5 abort |
| op_addr | input | AW | Word address |
| op_wdata | input | DW | Store word |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_data | output | DW | Loaded or stored word |
| resp_ok | output | 1 | Success or returned status |
| resp_ovf | output | 1 | Aborted for lack of entries |
| tactive | output | 1 | Transaction in progress |
| tstatus | output | 1 | Transaction not aborted |
| bm_req | output | 1 | Bus request |
| bm_cmd | output | 2 | 0 T_READ, 1 T_RFO, 2 write-back |
| bm_addr | output | AW | Bus address |
| bm_wdata | output | DW | Write-back word |
| bm_ack | input | 1 | Bus completion |
| bm_busy | input | 1 | Read refused by another agent |
| bm_rdata | input | DW | Read word |
| sn_valid | input | 1 | Snooped cycle present |
| sn_cmd | input | 2 | 0 READ, 1 T_READ, 2 RFO, 3 T_RFO |
| sn_addr | input | AW | Snooped address |
| sn_hit | output | 1 | Block supplies data |
| sn_busy | output | 1 | Block refuses the cycle |
| sn_data | output | DW | Supplied word |

## Verification
The assertions assume that `bm_ack` arrives only while a request is held, and only once per request. They also assume that `op_valid` is raised only while `op_ready` is high, and that a snooped RFO never strikes the line the allocator is working on at that moment. The bench's memory model acknowledges exactly one cycle after it sees a request. Snooped cycles are driven only between operations, while the block is idle, so the allocator never races a snoop. Busy replies are switched on only around a single chosen read.

// File: rtl/tcache.sv
module tcache #(
  parameter int N_ENT = 4,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [2:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          resp_ok,
  output logic          resp_ovf,
  output logic          tactive,
  output logic          tstatus,
  output logic          bm_req,
  output logic [1:0]    bm_cmd,
  output logic [AW-1:0] bm_addr,
  output logic [DW-1:0] bm_wdata,
  input  logic          bm_ack,
  input  logic          bm_busy,
  input  logic [DW-1:0] bm_rdata,
  input  logic          sn_valid,
  input  logic [1:0]    sn_cmd,
  input  logic [AW-1:0] sn_addr,
  output logic          sn_hit,
  output logic          sn_busy,
  output logic [DW-1:0] sn_data
);
  localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
  localparam logic [2:0] OP_LT = 3'd0, OP_LTX = 3'd1, OP_ST = 3'd2;
  localparam logic [2:0] OP_VAL = 3'd3, OP_COM = 3'd4, OP_ABT = 3'd5;
  localparam logic [1:0] SN_TREAD = 2'd1;

  typedef enum logic [1:0] {T_EMPTY, T_NORMAL, T_XCOMMIT, T_XABORT} tag_t;
  typedef enum logic [1:0] {S_IDLE, S_ALLOC, S_WB, S_FETCH} st_t;

  st_t             st;
  tag_t            tg [N_ENT];
  logic [AW-1:0]   ad [N_ENT];
  logic [DW-1:0]   dt [N_ENT];
  logic [N_ENT-1:0] dty;
  logic [2:0]      q_op;
  logic [AW-1:0]   q_addr;
  logic [DW-1:0]   q_wdata;
  logic [IW-1:0]   v_q;

  function automatic logic [IW-1:0] first1(input logic [N_ENT-1:0] v);
    first1 = '0;
    for (int i = N_ENT - 1; i >= 0; i--) if (v[i]) first1 = IW'(i);
  endfunction

  logic [AW-1:0] key;
  logic [N_ENT-1:0] v_e, v_n, v_xc, v_xa, mk, ms;
  assign key = (st == S_IDLE) ? op_addr : q_addr;

  always_comb
    for (int i = 0; i < N_ENT; i++) begin
      v_e[i]  = (tg[i] == T_EMPTY);
      v_n[i]  = (tg[i] == T_NORMAL);
      v_xc[i] = (tg[i] == T_XCOMMIT);
      v_xa[i] = (tg[i] == T_XABORT);
      mk[i]   = (ad[i] == key);
      ms[i]   = (ad[i] == sn_addr);
    end

  logic [N_ENT-1:0] hit_xa, hit_n, cand_n, sn_n, sn_xc, sn_xa;
  assign hit_xa = mk & v_xa;
  assign hit_n  = mk & v_n;
  assign cand_n = v_n & ~hit_n;
  assign sn_n   = ms & v_n;
  assign sn_xc  = ms & v_xc;
  assign sn_xa  = ms & v_xa;

  logic [IW-1:0] e1, e2, xa_i, n_i, vic;
  logic have_vic, enough;
  int n_empty;
  assign e1       = first1(v_e);
  assign e2       = first1(v_e & ~(N_ENT'(1) << e1));
  assign xa_i     = first1(hit_xa);
  assign n_i      = first1(hit_n);
  assign vic      = (|cand_n) ? first1(cand_n) : first1(v_xc);
  assign have_vic = (|cand_n) | (|v_xc);
  assign n_empty  = $countones(v_e);
  assign enough   = n_empty >= ((|hit_n) ? 1 : 2);

  logic is_mem, rt_commit, rt_abort, ovf_now, busy_now, sn_inv;
  assign is_mem    = (op_code == OP_LT) || (op_code == OP_LTX) || (op_code == OP_ST);
  assign ovf_now   = (st == S_ALLOC) && !enough && !have_vic;
  assign busy_now  = (st == S_FETCH) && bm_ack && bm_busy;
  assign rt_commit = (st == S_IDLE) && op_valid && (op_code == OP_COM) && tstatus;
  assign rt_abort  = ((st == S_IDLE) && op_valid && (op_code == OP_ABT)) || ovf_now || busy_now;
  assign sn_inv    = sn_valid && sn_cmd[1] && (|sn_n);

  assign op_ready = (st == S_IDLE);
  assign bm_req   = (st == S_WB) || (st == S_FETCH);
  assign bm_cmd   = (st == S_WB) ? 2'd2 : ((q_op == OP_LT) ? 2'd0 : 2'd1);
  assign bm_addr  = (st == S_WB) ? ad[v_q] : q_addr;
  assign bm_wdata = dt[v_q];

  assign sn_hit  = sn_valid && ((|sn_n) || (tstatus && sn_cmd == SN_TREAD && (|sn_xc)));
  assign sn_busy = sn_valid && tstatus && (|(sn_xa | sn_xc)) && (sn_cmd != SN_TREAD);
  assign sn_data = (|sn_n) ? dt[first1(sn_n)] : dt[first1(sn_xc)];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE;
      for (int i = 0; i < N_ENT; i++) begin
        tg[i] <= T_EMPTY; ad[i] <= '0; dt[i] <= '0;
      end
      dty <= '0; q_op <= '0; q_addr <= '0; q_wdata <= '0; v_q <= '0;
      tactive <= 1'b0; tstatus <= 1'b1;
      resp_valid <= 1'b0; resp_data <= '0; resp_ok <= 1'b0; resp_ovf <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      resp_ovf <= 1'b0;
      if (sn_inv) tg[first1(sn_n)] <= T_EMPTY;
      case (st)
        S_IDLE: if (op_valid) begin
          q_op <= op_code; q_addr <= op_addr; q_wdata <= op_wdata;
          if (is_mem) begin
            if (!tstatus) begin
              resp_valid <= 1'b1; resp_ok <= 1'b0; resp_data <= '0;
            end else begin
              tactive <= 1'b1;
              if (|hit_xa) begin
                resp_valid <= 1'b1; resp_ok <= 1'b1;
                if (op_code == OP_ST) begin
                  dt[xa_i] <= op_wdata; dty[xa_i] <= 1'b1; resp_data <= op_wdata;
                end else resp_data <= dt[xa_i];
              end else st <= S_ALLOC;
            end
          end else begin
            resp_valid <= 1'b1; resp_data <= '0;
            resp_ok <= (op_code == OP_ABT) ? 1'b1 : tstatus;
            if (op_code == OP_ABT || op_code == OP_COM || (op_code == OP_VAL && !tstatus)) begin
              tactive <= 1'b0; tstatus <= 1'b1;
            end
          end
        end
        S_ALLOC:
          if (enough) begin
            if (|hit_n) begin
              tg[n_i] <= T_XABORT;
              tg[e1] <= T_XCOMMIT; ad[e1] <= q_addr; dt[e1] <= dt[n_i]; dty[e1] <= dty[n_i];
              resp_valid <= 1'b1; resp_ok <= 1'b1;
              if (q_op == OP_ST) begin
                dt[n_i] <= q_wdata; dty[n_i] <= 1'b1; resp_data <= q_wdata;
              end else resp_data <= dt[n_i];
              st <= S_IDLE;
            end else st <= S_FETCH;
          end else if (have_vic) begin
            if (tg[vic] == T_NORMAL && !dty[vic]) tg[vic] <= T_EMPTY;
            else begin v_q <= vic; st <= S_WB; end
          end else begin
            tstatus <= 1'b0;
            resp_valid <= 1'b1; resp_ok <= 1'b0; resp_ovf <= 1'b1; resp_data <= '0;
            st <= S_IDLE;
          end
        S_WB: if (bm_ack) begin
          tg[v_q] <= T_EMPTY; dty[v_q] <= 1'b0; st <= S_ALLOC;
        end
        S_FETCH: if (bm_ack) begin
          resp_valid <= 1'b1;
          st <= S_IDLE;
          if (bm_busy) begin
            tstatus <= 1'b0; resp_ok <= 1'b0; resp_data <= '0;
          end else begin
            tg[e1] <= T_XABORT; ad[e1] <= q_addr;
            tg[e2] <= T_XCOMMIT; ad[e2] <= q_addr; dt[e2] <= bm_rdata; dty[e2] <= 1'b0;
            resp_ok <= 1'b1;
            if (q_op == OP_ST) begin
              dt[e1] <= q_wdata; dty[e1] <= 1'b1; resp_data <= q_wdata;
            end else begin
              dt[e1] <= bm_rdata; dty[e1] <= 1'b0; resp_data <= bm_rdata;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
      for (int i = 0; i < N_ENT; i++) begin
        if (rt_commit) begin
          if (tg[i] == T_XABORT) tg[i] <= T_NORMAL;
          else if (tg[i] == T_XCOMMIT) tg[i] <= T_EMPTY;
        end
        if (rt_abort) begin
          if (tg[i] == T_XABORT) tg[i] <= T_EMPTY;
          else if (tg[i] == T_XCOMMIT) tg[i] <= T_NORMAL;
        end
      end
    end

  a_r8_flag_pair: assert property (@(posedge clk) disable iff (!rst_n)
    !tactive |-> tstatus);
  a_r4_copies_paired: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(v_xc) <= $countones(v_xa));
  a_r5_commit_retag: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && op_valid && op_code == OP_COM && tstatus) |=>
      ($countones(v_xa) == 0 && $countones(v_xc) == 0 && !tactive));
  a_r7_busy_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && bm_ack && bm_busy) |=> (!tstatus && tactive && $countones(v_xa) == 0));
  a_r10_overflow_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_ovf) |-> (!resp_ok && !tstatus && $countones(v_xa) == 0));
  a_r12_snoop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    sn_busy |-> (!sn_hit && tstatus));
  a_r2_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bm_req) && !$past(bm_ack)) |-> (bm_req && $stable(bm_addr) && $stable(bm_cmd)));
endmodule

// File: tb/tcache_tb_top.sv
module tcache_tb_top;
  localparam int AW = 8, DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic op_valid = 0, op_ready, resp_valid, resp_ok, resp_ovf, tactive, tstatus;
  logic [2:0] op_code = 0;
  logic [AW-1:0] op_addr = 0, bm_addr, sn_addr = 0;
  logic [DW-1:0] op_wdata = 0, resp_data, bm_wdata, bm_rdata = 0, sn_data;
  logic bm_req, bm_ack = 0, bm_busy = 0, sn_valid = 0, sn_hit, sn_busy;
  logic [1:0] bm_cmd, sn_cmd = 0;

  tcache #(.N_ENT(4), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code),
    .op_addr(op_addr), .op_wdata(op_wdata), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_ok(resp_ok), .resp_ovf(resp_ovf), .tactive(tactive), .tstatus(tstatus),
    .bm_req(bm_req), .bm_cmd(bm_cmd), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_ack(bm_ack), .bm_busy(bm_busy), .bm_rdata(bm_rdata), .sn_valid(sn_valid),
    .sn_cmd(sn_cmd), .sn_addr(sn_addr), .sn_hit(sn_hit), .sn_busy(sn_busy), .sn_data(sn_data));

  logic [DW-1:0] mem [256];
  logic wrote [256];
  int nrd = 0, nwr = 0, tests = 0, fails = 0;
  logic [1:0] last_rcmd = 0;
  logic [AW-1:0] last_raddr = 0, last_waddr = 0;
  logic [DW-1:0] last_wdata = 0;
  logic inject = 0, finished = 0;

  initial for (int i = 0; i < 256; i++) begin mem[i] = {i[7:0], i[7:0]}; wrote[i] = 0; end

  always @(posedge clk)
    if (bm_ack) bm_ack <= 1'b0;
    else if (bm_req) begin
      bm_ack <= 1'b1;
      if (bm_cmd == 2'd2) begin
        mem[bm_addr] <= bm_wdata; wrote[bm_addr] <= 1'b1;
        nwr <= nwr + 1; last_waddr <= bm_addr; last_wdata <= bm_wdata; bm_busy <= 1'b0;
      end else begin
        bm_rdata <= mem[bm_addr]; bm_busy <= inject;
        nrd <= nrd + 1; last_rcmd <= bm_cmd; last_raddr <= bm_addr;
      end
    end

  logic r_ok, r_ovf, s_hit, s_busy;
  logic [DW-1:0] r_data, s_data;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] w);
    @(negedge clk);
    op_valid = 1; op_code = c; op_addr = a; op_wdata = w;
    @(negedge clk);
    op_valid = 0;
    while (!resp_valid) @(negedge clk);
    r_ok = resp_ok; r_data = resp_data; r_ovf = resp_ovf;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    sn_valid = 1; sn_cmd = c; sn_addr = a;
    #1;
    s_hit = sn_hit; s_busy = sn_busy; s_data = sn_data;
    @(negedge clk);
    sn_valid = 0;
  endtask

  task automatic t_reset;
    check("R1 tactive", tactive, 0);
    check("R1 tstatus", tstatus, 1);
    check("R1 bm_req", bm_req, 0);
    check("R1 op_ready", op_ready, 1);
    check("R1 resp_valid", resp_valid, 0);
    snoop(2'd0, 8'h10);
    check("R1 no snoop hit", s_hit, 0);
  endtask

  task automatic t_load;
    do_op(3'd0, 8'h10, 0);
    check("R2 data", r_data, 16'h1010);
    check("R2 ok", r_ok, 1);
    check("R2 one read", nrd, 1);
    check("R2 read cmd", last_rcmd, 0);
    check("R2 read addr", last_raddr, 8'h10);
    check("R2 tactive", tactive, 1);
    do_op(3'd3, 0, 0);
    check("R8 validate true", r_ok, 1);
    check("R8 tactive kept", tactive, 1);
    do_op(3'd0, 8'h10, 0);
    check("R3 reload data", r_data, 16'h1010);
    check("R3 no new read", nrd, 1);
  endtask

  task automatic t_store_commit;
    do_op(3'd2, 8'h10, 16'hAAAA);
    check("R3 store ok", r_ok, 1);
    check("R3 store no bus", nrd, 1);
    do_op(3'd0, 8'h10, 0);
    check("R3 load sees store", r_data, 16'hAAAA);
    snoop(2'd1, 8'h10);
    check("R12 tread hit", s_hit, 1);
    check("R12 tread old word", s_data, 16'h1010);
    check("R12 tread not busy", s_busy, 0);
    snoop(2'd0, 8'h10);
    check("R12 read busy", s_busy, 1);
    check("R12 read no hit", s_hit, 0);
    do_op(3'd4, 0, 0);
    check("R5 commit ok", r_ok, 1);
    check("R5 tactive cleared", tactive, 0);
    snoop(2'd0, 8'h10);
    check("R5 committed word", s_data, 16'hAAAA);
    check("R11 normal read hit", s_hit, 1);
    check("R11 normal not busy", s_busy, 0);
  endtask

  task automatic t_abort;
    do_op(3'd0, 8'h10, 0);
    check("R4 normal hit data", r_data, 16'hAAAA);
    check("R4 no bus", nrd, 1);
    snoop(2'd1, 8'h10);
    check("R4 copy keeps old word", s_data, 16'hAAAA);
    do_op(3'd2, 8'h10, 16'h5555);
    do_op(3'd5, 0, 0);
    check("R6 abort ok", r_ok, 1);
    check("R6 tactive cleared", tactive, 0);
    snoop(2'd0, 8'h10);
    check("R6 old word back", s_data, 16'hAAAA);
    check("R6 line normal", s_hit, 1);
    do_op(3'd1, 8'h20, 0);
    check("R2 ltx data", r_data, 16'h2020);
    check("R2 ltx cmd", last_rcmd, 1);
    do_op(3'd4, 0, 0);
  endtask

  task automatic t_evict;
    do_op(3'd0, 8'h30, 0);
    check("R9 empties used, no write", nwr, 0);
    do_op(3'd0, 8'h40, 0);
    check("R9 load after evict", r_data, 16'h4040);
    check("R9 one write-back", nwr, 1);
    check("R9 dirty normal addr", last_waddr, 8'h10);
    check("R9 dirty normal word", last_wdata, 16'hAAAA);
    check("R9 clean normal dropped", wrote[8'h20], 0);
    check("R9 commit-copy kept over normal", wrote[8'h30], 0);
    do_op(3'd0, 8'h50, 0);
    check("R9 commit-copies written", nwr, 3);
    check("R9 wb 30", wrote[8'h30], 1);
    check("R9 wb 40", wrote[8'h40], 1);
    check("R9 wb word", mem[8'h30], 16'h3030);
    do_op(3'd2, 8'h60, 16'h1234);
    check("R10 ok", r_ok, 0);
    check("R10 ovf", r_ovf, 1);
    check("R10 no read", nrd, 5);
    check("R10 tstatus", tstatus, 0);
    check("R10 tactive", tactive, 1);
    snoop(2'd0, 8'h40);
    check("R10 updates dropped", s_hit, 0);
    check("R10 no busy", s_busy, 0);
    do_op(3'd3, 0, 0);
    check("R8 validate false", r_ok, 0);
    check("R8 tactive reset", tactive, 0);
    check("R8 tstatus reset", tstatus, 1);
  endtask

  task automatic t_busy;
    do_op(3'd0, 8'h10, 0);
    check("R2 refetch", r_data, 16'hAAAA);
    do_op(3'd2, 8'h10, 16'h1234);
    inject = 1;
    do_op(3'd0, 8'h70, 0);
    inject = 0;
    check("R7 ok", r_ok, 0);
    check("R7 tstatus", tstatus, 0);
    check("R7 tactive", tactive, 1);
    check("R7 read made", nrd, 7);
    do_op(3'd0, 8'h10, 0);
    check("R7 ignored op", r_ok, 0);
    check("R7 ignored no bus", nrd, 7);
    snoop(2'd0, 8'h10);
    check("R7 old word restored", s_data, 16'hAAAA);
    check("R7 line normal", s_hit, 1);
    do_op(3'd4, 0, 0);
    check("R8 commit false", r_ok, 0);
    check("R8 commit tactive", tactive, 0);
    check("R8 commit tstatus", tstatus, 1);
  endtask

  task automatic t_rfo;
    snoop(2'd2, 8'h10);
    check("R11 rfo hit", s_hit, 1);
    check("R11 rfo word", s_data, 16'hAAAA);
    snoop(2'd0, 8'h10);
    check("R11 rfo freed line", s_hit, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_store_commit();
    t_abort();
    t_evict();
    t_busy();
    t_rfo();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule